// File: doc/BRIEF.md
# Single-Port Memory with Retention and Power-Down Sleep

This block is a synchronous single-port memory with two low-power states. It stores words of a parameterised width and serves one access per clock. A read is captured into an output register and shows on the read bus one cycle later. Two separate request inputs control the low-power states. A light request puts the periphery to sleep and keeps the stored words. A deep request powers the whole memory down, and the stored words are lost.

A small power-state controller sequences each change. It passes through a fixed entry phase, the sleep state itself, and a wake phase whose length depends on the kind of sleep. The memory serves accesses only while the controller is active, and a ready output shows that state. While asleep, the read bus is clamped to zero. After a deep sleep, each word reads as all ones until it is written again. An access attempted while not ready is dropped, and an error flag reports it.

Top module: `sram_sleep`

## Requirements
- R1: An access with `mem_en`=1 and `wr_en`=1 while `ready`=1 stores `wdata` at `addr` and leaves `rdata` unchanged. An access with `mem_en`=1 and `wr_en`=0 while `ready`=1 puts the stored word on `rdata` in the following cycle.
- R2: After reset, `ready`=1, `rdata`=0 and `acc_err`=0. Every word reads as all ones until it is first written.
- R3: `rdata` is all zeros in every cycle the block is in a sleep state. It stays zero through the wake phase until the next accepted read.
- R4: Words written before a light sleep read back unchanged after the block leaves light sleep.
- R5: After a deep sleep, every word reads as all ones until it is rewritten. A rewritten word reads back its new value.
- R6: `ready` is high only in the active state. A sleep request sampled while active makes `ready` low for ENTER_LAT cycles of entry before the sleep state. An access while `ready`=0 changes neither the stored words nor `rdata`.
- R7: From the first clock edge that samples the request released, `ready` stays low for LS_WAKE cycles after a light sleep (default 2) and DS_WAKE cycles after a deep sleep (default 8).
- R8: `acc_err` is high in the cycle after a cycle with `mem_en`=1 and `ready`=0, and low after every other cycle.
- R9: When both requests are high while active, the block enters deep sleep. A deep request while in light sleep moves the block through entry into deep sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | input | 1 | Access request |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| light_req | input | 1 | Request light sleep (contents kept) |
| deep_req | input | 1 | Request deep sleep (contents lost) |
| rdata | output | DATA_W | Registered read data, clamped to zero while asleep |
| ready | output | 1 | High only while accesses are accepted |
| acc_err | output | 1 | One-cycle flag for a dropped access |

## Verification
The assertions check on every cycle that the read bus is clamped while asleep and held through wake. They also check the error flag after every access and the priority of the deep request. A counter measures each wake phase against its parameter. Only the bench's scenarios can show that data survives light sleep and is lost after deep sleep, that rewrites restore words, and that dropped writes leave the stored words alone. Each of these depends on values written many cycles earlier.

// File: rtl/sram_sleep_pkg.sv
package sram_sleep_pkg;
  typedef enum logic [2:0] {
    PS_ACTIVE   = 3'd0,
    PS_ENTER_LS = 3'd1,
    PS_LIGHT    = 3'd2,
    PS_WAKE_LS  = 3'd3,
    PS_ENTER_DS = 3'd4,
    PS_DEEP     = 3'd5,
    PS_WAKE_DS  = 3'd6
  } pwr_state_t;
endpackage

// File: rtl/sram_sleep_pwr.sv
module sram_sleep_pwr
  import sram_sleep_pkg::*;
#(
  parameter int ENTER_LAT = 1,
  parameter int LS_WAKE   = 2,
  parameter int DS_WAKE   = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ls_req,
  input  logic       ds_req,
  output pwr_state_t state,
  output logic       ready,
  output logic       sleep_enter,
  output logic       deep_enter
);
  localparam int MAXL = (DS_WAKE > LS_WAKE) ?
                        ((DS_WAKE > ENTER_LAT) ? DS_WAKE : ENTER_LAT) :
                        ((LS_WAKE > ENTER_LAT) ? LS_WAKE : ENTER_LAT);
  localparam int CW = $clog2(MAXL + 1);
  localparam logic [CW-1:0] ENT_LD = CW'(ENTER_LAT - 1);
  localparam logic [CW-1:0] LSW_LD = CW'(LS_WAKE - 1);
  localparam logic [CW-1:0] DSW_LD = CW'(DS_WAKE - 1);

  pwr_state_t    state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    unique case (state)
      PS_ACTIVE: begin
        if (ds_req) begin
          state_n = PS_ENTER_DS;
          cnt_n   = ENT_LD;
        end else if (ls_req) begin
          state_n = PS_ENTER_LS;
          cnt_n   = ENT_LD;
        end
      end
      PS_ENTER_LS: begin
        if (cnt_zero) state_n = PS_LIGHT;
        else          cnt_n   = cnt - 1'b1;
      end
      PS_LIGHT: begin
        if (ds_req) begin
          state_n = PS_ENTER_DS;
          cnt_n   = ENT_LD;
        end else if (!ls_req) begin
          state_n = PS_WAKE_LS;
          cnt_n   = LSW_LD;
        end
      end
      PS_WAKE_LS: begin
        if (cnt_zero) state_n = PS_ACTIVE;
        else          cnt_n   = cnt - 1'b1;
      end
      PS_ENTER_DS: begin
        if (cnt_zero) state_n = PS_DEEP;
        else          cnt_n   = cnt - 1'b1;
      end
      PS_DEEP: begin
        if (!ds_req) begin
          state_n = PS_WAKE_DS;
          cnt_n   = DSW_LD;
        end
      end
      PS_WAKE_DS: begin
        if (cnt_zero) state_n = PS_ACTIVE;
        else          cnt_n   = cnt - 1'b1;
      end
      default: state_n = PS_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_ACTIVE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end
  end

  assign ready       = (state == PS_ACTIVE);
  assign sleep_enter = cnt_zero && (state == PS_ENTER_LS || state == PS_ENTER_DS);
  assign deep_enter  = cnt_zero && (state == PS_ENTER_DS);
endmodule

// File: rtl/sram_sleep_array.sv
module sram_sleep_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ok,
  input  logic              rd_ok,
  input  logic              clamp,
  input  logic              wipe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [DATA_W-1:0] LOST_WORD = '1;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  live;

  always_ff @(posedge clk) begin
    if (wr_ok) store[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)        live <= '0;
    else if (wipe)  live <= '0;
    else if (wr_ok) live[addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (clamp) rdata <= '0;
    else if (rd_ok) rdata <= live[addr] ? store[addr] : LOST_WORD;
  end
endmodule

// File: rtl/sram_sleep.sv
module sram_sleep
  import sram_sleep_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int ENTER_LAT = 1,
  parameter int LS_WAKE   = 2,
  parameter int DS_WAKE   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              light_req,
  input  logic              deep_req,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              acc_err
);
  pwr_state_t pwr_state;
  logic       sleep_enter, deep_enter;
  logic       wr_ok, rd_ok;

  sram_sleep_pwr #(
    .ENTER_LAT(ENTER_LAT), .LS_WAKE(LS_WAKE), .DS_WAKE(DS_WAKE)
  ) u_pwr (
    .clk(clk), .rst(rst), .ls_req(light_req), .ds_req(deep_req),
    .state(pwr_state), .ready(ready),
    .sleep_enter(sleep_enter), .deep_enter(deep_enter)
  );

  assign wr_ok = mem_en &  wr_en & ready;
  assign rd_ok = mem_en & ~wr_en & ready;

  sram_sleep_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst), .wr_ok(wr_ok), .rd_ok(rd_ok),
    .clamp(sleep_enter), .wipe(deep_enter),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) acc_err <= 1'b0;
    else     acc_err <= mem_en & ~ready;
  end
endmodule

// File: rtl/sram_sleep_chk.sv
module sram_sleep_chk
  import sram_sleep_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int LS_WAKE = 2,
  parameter int DS_WAKE = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_en,
  input logic              deep_req,
  input logic              ready,
  input logic              acc_err,
  input logic [DATA_W-1:0] rdata,
  input pwr_state_t        state
);
  int wake_cycles;
  always_ff @(posedge clk) begin
    if (rst) wake_cycles <= 0;
    else if (state == PS_WAKE_LS || state == PS_WAKE_DS) wake_cycles <= wake_cycles + 1;
    else wake_cycles <= 0;
  end

  a_r3_clamp_asleep: assert property (@(posedge clk) disable iff (rst)
    (state == PS_LIGHT || state == PS_DEEP) |-> (rdata == '0));

  a_r3_hold_while_waking: assert property (@(posedge clk) disable iff (rst)
    (state == PS_WAKE_LS || state == PS_WAKE_DS) |=> $stable(rdata));

  a_r8_err_after_blocked: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !ready) |=> acc_err);

  a_r8_err_quiet: assert property (@(posedge clk) disable iff (rst)
    (!mem_en || ready) |=> !acc_err);

  a_r9_deep_wins: assert property (@(posedge clk) disable iff (rst)
    ((state == PS_ACTIVE || state == PS_LIGHT) && deep_req) |=> (state == PS_ENTER_DS));

  a_r7_ls_wake_len: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(state) == PS_WAKE_LS) |-> (wake_cycles == LS_WAKE));

  a_r7_ds_wake_len: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(state) == PS_WAKE_DS) |-> (wake_cycles == DS_WAKE));
endmodule

bind sram_sleep sram_sleep_chk #(
  .DATA_W(DATA_W), .LS_WAKE(LS_WAKE), .DS_WAKE(DS_WAKE)
) u_chk (
  .clk(clk), .rst(rst), .mem_en(mem_en), .deep_req(deep_req),
  .ready(ready), .acc_err(acc_err), .rdata(rdata), .state(pwr_state)
);

// File: tb/sram_sleep_tb.sv
module sram_sleep_tb;
  localparam int AW = 6;
  localparam int DW = 16;
  localparam int ENT = 1;
  localparam int LSW = 2;
  localparam int DSW = 8;
  localparam logic [DW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mem_en = 1'b0, wr_en = 1'b0, light_req = 1'b0, deep_req = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ready, acc_err;

  int checks = 0;
  int errors = 0;
  int n;

  always #5 clk = ~clk;

  sram_sleep #(.ADDR_W(AW), .DATA_W(DW), .ENTER_LAT(ENT), .LS_WAKE(LSW), .DS_WAKE(DSW)) u_dut (
    .clk(clk), .rst(rst), .mem_en(mem_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .light_req(light_req), .deep_req(deep_req), .rdata(rdata), .ready(ready), .acc_err(acc_err)
  );

  // behavioural reference: mode 0 active, 1 entering, 2 asleep, 3 waking
  int mode, cnt;
  bit deep;
  logic [DW-1:0] m_mem [int];
  logic [DW-1:0] m_rdata;
  bit m_err;

  always @(posedge clk) begin
    if (rst) begin
      mode = 0; cnt = 0; deep = 0; m_rdata = '0; m_err = 0;
      m_mem.delete();
    end else begin
      bit rdy;
      rdy = (mode == 0);
      m_err = mem_en && !rdy;
      if (rdy && mem_en && wr_en) m_mem[int'(addr)] = wdata;
      else if (rdy && mem_en) m_rdata = m_mem.exists(int'(addr)) ? m_mem[int'(addr)] : ONES;
      case (mode)
        0: if (deep_req) begin mode = 1; deep = 1; cnt = ENT; end
           else if (light_req) begin mode = 1; deep = 0; cnt = ENT; end
        1: begin
             cnt--;
             if (cnt == 0) begin
               mode = 2; m_rdata = '0;
               if (deep) m_mem.delete();
             end
           end
        2: if (deep) begin
             if (!deep_req) begin mode = 3; cnt = DSW; end
           end else if (deep_req) begin mode = 1; deep = 1; cnt = ENT; end
           else if (!light_req) begin mode = 3; cnt = LSW; end
        default: begin cnt--; if (cnt == 0) mode = 0; end
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(ready == (mode == 0), "R6 ready per cycle", ready, (mode == 0));
      check(rdata == m_rdata, "R1 rdata per cycle", rdata, m_rdata);
      check(acc_err == m_err, "R8 acc_err per cycle", acc_err, m_err);
    end
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem_en = 1; wr_en = 1; addr = a; wdata = d; cyc(); mem_en = 0; wr_en = 0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
    mem_en = 1; wr_en = 0; addr = a; cyc(); mem_en = 0;
    check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic count_wake(output int cycles);
    cycles = 0;
    do begin cyc(); cycles++; end while (!ready && cycles < 100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 0;
    check(ready == 1'b1, "R2 ready after reset", ready, 1);
    check(rdata == '0, "R2 rdata after reset", rdata, 0);
    check(acc_err == 1'b0, "R2 acc_err after reset", acc_err, 0);
    do_read(6'd5, ONES, "R2 unwritten word");

    do_write(6'd1, 16'h1111);
    check(rdata == ONES, "R1 write leaves rdata", rdata, ONES);
    do_write(6'd3, 16'hA5C3);
    do_write(6'd63, 16'h0F0F);
    do_read(6'd1, 16'h1111, "R1 read back a1");
    do_read(6'd63, 16'h0F0F, "R1 read back a63");
    do_read(6'd3, 16'hA5C3, "R1 read back a3");

    // light sleep
    light_req = 1; cyc();
    check(ready == 1'b0, "R6 ready low during entry", ready, 0);
    check(rdata == 16'hA5C3, "R6 rdata held during entry", rdata, 16'hA5C3);
    cyc();
    check(rdata == '0, "R3 clamp in light sleep", rdata, 0);
    mem_en = 1; wr_en = 1; addr = 6'd3; wdata = 16'h1234; cyc(); mem_en = 0; wr_en = 0;
    check(acc_err == 1'b1, "R8 error after blocked write", acc_err, 1);
    cyc();
    check(acc_err == 1'b0, "R8 error is one cycle", acc_err, 0);
    light_req = 0;
    count_wake(n);
    check(n == LSW + 1, "R7 light wake latency", n, LSW + 1);
    check(rdata == '0, "R3 rdata zero after wake", rdata, 0);
    do_read(6'd3, 16'hA5C3, "R4 retained a3, blocked write dropped R6");
    do_read(6'd1, 16'h1111, "R4 retained a1");

    // deep sleep
    deep_req = 1; cyc(); cyc();
    check(rdata == '0, "R3 clamp in deep sleep", rdata, 0);
    mem_en = 1; wr_en = 0; addr = 6'd1; cyc(); mem_en = 0;
    check(acc_err == 1'b1, "R8 error after blocked read", acc_err, 1);
    check(rdata == '0, "R6 blocked read leaves rdata", rdata, 0);
    deep_req = 0;
    count_wake(n);
    check(n == DSW + 1, "R7 deep wake latency", n, DSW + 1);
    do_read(6'd1, ONES, "R5 lost word a1");
    do_read(6'd63, ONES, "R5 lost word a63");
    do_write(6'd1, 16'hBEEF);
    do_read(6'd1, 16'hBEEF, "R5 rewritten a1");
    do_read(6'd3, ONES, "R5 other word still lost");

    // both requests at once
    do_write(6'd7, 16'h7777);
    light_req = 1; deep_req = 1; cyc(); cyc();
    light_req = 0; deep_req = 0;
    count_wake(n);
    check(n == DSW + 1, "R9 both requests give deep wake", n, DSW + 1);
    do_read(6'd7, ONES, "R9 both requests lose data");

    // light escalated to deep
    do_write(6'd9, 16'h9999);
    light_req = 1; cyc(); cyc();
    deep_req = 1; cyc(); cyc();
    check(rdata == '0, "R9 clamp after escalation", rdata, 0);
    light_req = 0; deep_req = 0;
    count_wake(n);
    check(n == DSW + 1, "R9 escalation wake latency", n, DSW + 1);
    do_read(6'd9, ONES, "R9 escalation loses data");

    repeat (3) cyc();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule